// File: doc/BRIEF.md
# Presettable Up/Down Counter with Separate Count Strobes

This block is a modulo-16 binary counter whose direction is chosen by which of two count strobes moves. One strobe steps the value up and the other steps it down. Each strobe only acts while the other one rests at its idle high level. Both strobes are sampled by a single system clock. A low-to-high change on a sampled strobe is turned into a single step, so the strobes may be slow, level-style signals from elsewhere in the chip.

A synchronous clear sets the value to zero. An active-low load copies a four-bit preset word into the counter. Clear takes precedence over load, and load takes precedence over counting. Two active-low terminal flags are provided. The up flag drops while the up strobe is low and the value is at its maximum. The down flag drops while the down strobe is low and the value is zero. These flags can feed the strobes of a following stage to build wider counters. All outputs are registered.

Top module: `updown_preset_counter`

## Requirements
- R1: While `clr` is high at a rising `clk` edge, `count` becomes 0 at that edge, whatever `load_n` and the strobes do. Both sampled strobes are then treated as idle high, so a strobe that is held high after clear causes no step.
- R2: While `load_n` is low and `clr` is low, `count` takes the value of `preset` at that edge. Strobe transitions seen while `load_n` is low cause no step.
- R3: A low-to-high change of `cnt_up` while `cnt_dn` is high adds one to `count`. The new value is visible after the second rising `clk` edge that follows the change.
- R4: A low-to-high change of `cnt_dn` while `cnt_up` is high subtracts one from `count`, with the same latency as R3.
- R5: Counting wraps around: stepping up from 15 gives 0, and stepping down from 0 gives 15.
- R6: A low-to-high change of one strobe while the other strobe is sampled low leaves `count` unchanged.
- R7: If both strobes rise in the same sampling cycle, `count` is unchanged.
- R8: `tc_up_n` is 0 exactly when the `cnt_up` level sampled at the last edge is 0 and `count` is 15. Otherwise it is 1. It updates on the same edge as `count`.
- R9: `tc_dn_n` is 0 exactly when the `cnt_dn` level sampled at the last edge is 0 and `count` is 0. Otherwise it is 1. It updates on the same edge as `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register updates on its rising edge |
| clr | input | 1 | Synchronous active-high clear; highest priority |
| load_n | input | 1 | Active-low parallel load of `preset` |
| preset | input | WIDTH (4) | Value copied in while `load_n` is low |
| cnt_up | input | 1 | Up strobe; a rising change steps up while `cnt_dn` is high |
| cnt_dn | input | 1 | Down strobe; a rising change steps down while `cnt_up` is high |
| count | output | WIDTH (4) | Registered counter value |
| tc_up_n | output | 1 | Active-low up terminal flag |
| tc_dn_n | output | 1 | Active-low down terminal flag |

## Verification
The directed tests aim at the boundaries. The first is wrap-around at 15 and at 0: a design that saturates there would stick instead of wrapping. The second is the terminal flags at those same two values: a flag decoded from the count alone would already sit low while the strobe is still high. The tests also cover a strobe that moves while the other strobe is held low, where a design without the gate would step anyway. Two priority cases are covered: clear applied during a load, and strobe edges applied during a load. A wrong priority order would leave the preset in place, or add a step on top of the loaded value. Finally, a simultaneous rise of both strobes must hold the value, so a design that favours one direction shows up as a step.

// File: rtl/updown_ctr_pkg.sv
package updown_ctr_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  // Strobe index positions inside the packed strobe vectors
  localparam int unsigned IDX_UP = 0;
  localparam int unsigned IDX_DN = 1;
  localparam int unsigned NUM_STROBES = 2;

  // A rising strobe is honoured only while the opposite strobe rests high.
  function automatic step_e pick_step(input logic up_rise, input logic dn_rise,
                                      input logic up_lvl, input logic dn_lvl);
    logic go_up;
    logic go_dn;
    go_up = up_rise & dn_lvl;
    go_dn = dn_rise & up_lvl;
    if (go_up && !go_dn)      return STEP_INC;
    else if (go_dn && !go_up) return STEP_DEC;
    else                      return STEP_HOLD;
  endfunction

endpackage

// File: rtl/ctr_strobe_sampler.sv
module ctr_strobe_sampler #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic clr,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o,
  output logic level_next_o
);
  logic prev_q;

  // Level that the sampling flop will hold after this edge
  assign level_next_o = clr ? IDLE_LEVEL : strobe_i;

  always_ff @(posedge clk) begin
    if (clr) begin
      level_o <= IDLE_LEVEL;
      prev_q  <= IDLE_LEVEL;
    end else begin
      level_o <= strobe_i;
      prev_q  <= level_o;
    end
  end

  assign rise_o = level_o & ~prev_q;
endmodule

// File: rtl/ctr_value_core.sv
module ctr_value_core
  import updown_ctr_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  step_e            step,
  output logic [WIDTH-1:0] value_q,
  output logic [WIDTH-1:0] value_next
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    if (clr)          value_next = '0;
    else if (!load_n) value_next = preset;
    else begin
      unique case (step)
        STEP_INC: value_next = value_q + ONE;
        STEP_DEC: value_next = value_q - ONE;
        default:  value_next = value_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    value_q <= value_next;
  end
endmodule

// File: rtl/ctr_terminal_flags.sv
module ctr_terminal_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] value_next,
  input  logic             up_level_next,
  input  logic             dn_level_next,
  output logic             tc_up_n,
  output logic             tc_dn_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic at_top;
  logic at_bottom;

  assign at_top    = (value_next == TOP);
  assign at_bottom = (value_next == '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      tc_up_n <= 1'b1;
      tc_dn_n <= 1'b1;
    end else begin
      tc_up_n <= ~(~up_level_next & at_top);
      tc_dn_n <= ~(~dn_level_next & at_bottom);
    end
  end
endmodule

// File: rtl/updown_preset_counter.sv
module updown_preset_counter
  import updown_ctr_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  output logic [WIDTH-1:0] count,
  output logic             tc_up_n,
  output logic             tc_dn_n
);
  logic [NUM_STROBES-1:0] strobe_in;
  logic [NUM_STROBES-1:0] lvl;
  logic [NUM_STROBES-1:0] rise;
  logic [NUM_STROBES-1:0] lvl_next;
  logic [WIDTH-1:0]       value_next;
  step_e                  step;

  assign strobe_in[IDX_UP] = cnt_up;
  assign strobe_in[IDX_DN] = cnt_dn;

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_sampler
    ctr_strobe_sampler #(.IDLE_LEVEL(1'b1)) u_smp (
      .clk          (clk),
      .clr          (clr),
      .strobe_i     (strobe_in[g]),
      .level_o      (lvl[g]),
      .rise_o       (rise[g]),
      .level_next_o (lvl_next[g])
    );
  end

  assign step = pick_step(rise[IDX_UP], rise[IDX_DN], lvl[IDX_UP], lvl[IDX_DN]);

  ctr_value_core #(.WIDTH(WIDTH)) u_core (
    .clk        (clk),
    .clr        (clr),
    .load_n     (load_n),
    .preset     (preset),
    .step       (step),
    .value_q    (count),
    .value_next (value_next)
  );

  ctr_terminal_flags #(.WIDTH(WIDTH)) u_flags (
    .clk           (clk),
    .clr           (clr),
    .value_next    (value_next),
    .up_level_next (lvl_next[IDX_UP]),
    .dn_level_next (lvl_next[IDX_DN]),
    .tc_up_n       (tc_up_n),
    .tc_dn_n       (tc_dn_n)
  );
endmodule

// File: rtl/updown_preset_counter_chk.sv
module updown_preset_counter_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             clr,
  input logic             load_n,
  input logic [WIDTH-1:0] preset,
  input logic             cnt_up,
  input logic             cnt_dn,
  input logic [WIDTH-1:0] count,
  input logic             tc_up_n,
  input logic             tc_dn_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  assert_clear_zero_R1: assert property (@(posedge clk)
    started && $past(clr) |-> count == '0);

  assert_load_copies_R2: assert property (@(posedge clk) disable iff (clr)
    started && !$past(clr) && !$past(load_n) |-> count == $past(preset));

  // R3 R4 R5: counting moves at most one step per edge, modulo 2**WIDTH
  assert_single_step_R3: assert property (@(posedge clk) disable iff (clr)
    started && !$past(clr) && $past(load_n) |->
      (count == $past(count)) || (count == $past(count) + ONE) ||
      (count == $past(count) - ONE));

  assert_tc_up_R8: assert property (@(posedge clk) disable iff (clr)
    started && !$past(clr) |-> tc_up_n == !(!$past(cnt_up) && count == TOP));

  assert_tc_dn_R9: assert property (@(posedge clk) disable iff (clr)
    started && !$past(clr) |-> tc_dn_n == !(!$past(cnt_dn) && count == '0));
endmodule

bind updown_preset_counter updown_preset_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .clr     (clr),
  .load_n  (load_n),
  .preset  (preset),
  .cnt_up  (cnt_up),
  .cnt_dn  (cnt_dn),
  .count   (count),
  .tc_up_n (tc_up_n),
  .tc_dn_n (tc_dn_n)
);

// File: tb/sim_updown_preset_counter.sv
module sim_updown_preset_counter;
  localparam int unsigned WIDTH = 4;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             clr = 1'b1;
  logic             load_n = 1'b1;
  logic [WIDTH-1:0] preset = '0;
  logic             cnt_up = 1'b1;
  logic             cnt_dn = 1'b1;
  logic [WIDTH-1:0] count;
  logic             tc_up_n;
  logic             tc_dn_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updown_preset_counter #(.WIDTH(WIDTH)) u0 (
    .clk(clk), .clr(clr), .load_n(load_n), .preset(preset),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .count(count), .tc_up_n(tc_up_n), .tc_dn_n(tc_dn_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [WIDTH-1:0] v);
    preset = v; load_n = 1'b0; cyc(1);
    load_n = 1'b1; cyc(1);
  endtask

  task automatic pulse_up();
    cnt_up = 1'b0; cyc(2); cnt_up = 1'b1; cyc(2);
  endtask

  task automatic pulse_dn();
    cnt_dn = 1'b0; cyc(2); cnt_dn = 1'b1; cyc(2);
  endtask

  task automatic t_reset();
    clr = 1'b1; cyc(1);
    chk("R1 count after clear", count, 0);
    chk("R1 tc_up_n after clear", tc_up_n, 1);
    chk("R1 tc_dn_n after clear", tc_dn_n, 1);
    clr = 1'b0; cyc(3);
    chk("R1 held-high strobes make no step", count, 0);
  endtask

  task automatic t_up();
    for (int i = 0; i < 5; i++) pulse_up();
    chk("R3 five up steps", count, 5);
  endtask

  task automatic t_load();
    preset = 4'd9; load_n = 1'b0; cyc(1);
    chk("R2 preset copied", count, 9);
    pulse_up();
    chk("R2 strobe ignored during load", count, 9);
    load_n = 1'b1; cyc(2);
    chk("R2 value kept after load", count, 9);
  endtask

  task automatic t_clear_over_load();
    preset = 4'd7; load_n = 1'b0; clr = 1'b1; cyc(1);
    chk("R1 clear beats load", count, 0);
    clr = 1'b0; load_n = 1'b1; cyc(2);
  endtask

  task automatic t_down();
    do_load(4'd9);
    for (int i = 0; i < 3; i++) pulse_dn();
    chk("R4 three down steps", count, 6);
  endtask

  task automatic t_wrap_up();
    do_load(4'd15);
    cnt_up = 1'b0; cyc(1);
    chk("R8 tc_up_n low at 15 with strobe low", tc_up_n, 0);
    chk("R9 tc_dn_n high at 15", tc_dn_n, 1);
    cnt_up = 1'b1; cyc(1);
    chk("R8 tc_up_n high once strobe high", tc_up_n, 1);
    cyc(1);
    chk("R5 wrap 15 to 0", count, 0);
    chk("R9 tc_dn_n high at 0 with strobe high", tc_dn_n, 1);
  endtask

  task automatic t_wrap_dn();
    cnt_dn = 1'b0; cyc(1);
    chk("R9 tc_dn_n low at 0 with strobe low", tc_dn_n, 0);
    cnt_dn = 1'b1; cyc(2);
    chk("R5 wrap 0 to 15", count, 15);
    chk("R9 tc_dn_n high after wrap", tc_dn_n, 1);
  endtask

  task automatic t_inhibit();
    do_load(4'd4);
    cnt_dn = 1'b0; cyc(2);
    pulse_up();
    chk("R6 up strobe gated by low down strobe", count, 4);
    cnt_dn = 1'b1; cyc(2);
    chk("R4 down rise with up high", count, 3);
  endtask

  task automatic t_simul();
    do_load(4'd4);
    cnt_up = 1'b0; cnt_dn = 1'b0; cyc(2);
    chk("R8 tc_up_n high when not 15", tc_up_n, 1);
    chk("R9 tc_dn_n high when not 0", tc_dn_n, 1);
    cnt_up = 1'b1; cnt_dn = 1'b1; cyc(3);
    chk("R7 simultaneous rise holds", count, 4);
  endtask

  initial begin
    cyc(2);
    t_reset();
    t_up();
    t_load();
    t_clear_over_load();
    t_down();
    t_wrap_up();
    t_wrap_dn();
    t_inhibit();
    t_simul();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule